// File: doc/BRIEF.md
# Two-Wire Register Read Target

This block is a target on a two-wire serial bus (I2C) that exposes a bank of sixteen 9-bit registers for reading. A host sends a control byte holding a 7-bit target address and a read/write flag, and on writes a command byte that names a register and an operation. The block keeps an internal pointer loaded by every valid command byte. Each read returns the pointed register as a pair of bytes, the one holding bit 8 first and bits 7..0 second. Reads may be single, random (a command byte followed by a repeated START and a read control byte) or continuous, where the host keeps acknowledging and the pair is sent again, re-read from the register port each time.

SCL and SDA are sampled on a system clock at least eight times the bus rate through two-flop synchronisers. The block only pulls SDA low through an output-enable, and changes that enable only while SCL is low. A command byte with an undefined operation code is taken as bus corruption: the block lets go of SDA and stays silent until a new START followed by a matching control byte. While an external busy flag reports a non-volatile write in progress, the registers at and above a set address cannot be read.

Top module: `i2c_rd_target`

## Requirements
- R1: After reset the SDA output-enable is 0 and the register read address is 0.
- R2: A control byte is acknowledged only when its bits [7:1] equal the fixed six upper address bits 010111 followed by the strap input; on a mismatch no ACK is given and no later byte is acknowledged until a new START.
- R3: A command byte carries the register address in bits [7:4] and the opcode in bits [3:2]; opcode 00 (write) is acknowledged and loads the pointer, which appears on the read address port, and bytes that follow it are acknowledged and discarded with the pointer unchanged.
- R4: A command byte with opcode 01 or 10 is not acknowledged, leaves the pointer unchanged, and every following byte, even a matching control byte, is left without ACK until a new START.
- R5: After a control byte with bit 0 = 1, the target sends the pointed register MSB first as a high byte equal to {7'b0, bit 8} and then a low byte equal to bits [7:0].
- R6: With no command byte since reset, a read returns register 0.
- R7: Opcode 11 (read) loads the pointer; a repeated START followed by a read control byte then returns the newly addressed register.
- R8: When the host acknowledges the low byte, the target sends another high/low pair of the same register, sampled afresh from the register port.
- R9: When the host does not acknowledge a byte, the target leaves SDA released until the next START, and the pointer keeps its value for later reads.
- R10: While the busy input is 1, an opcode-11 command naming an address of 2 or more is rejected as in R4, and a read control byte is not acknowledged while the pointer is 2 or more; opcode 00 commands are still accepted.
- R11: The SDA output-enable never changes while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| addr_strap | input | 1 | Lowest bit of the 7-bit target address |
| nv_busy | input | 1 | Non-volatile write in progress |
| rf_raddr | output | 4 | Register file read address (the pointer) |
| rf_rdata | input | 9 | Register file read data, one clock after the address |

## Verification
The two functions that can meet in one system-clock cycle are the command decode, which judges a finished byte against the busy flag and the pointer, and the bus-condition detector, which can see a repeated START in the SCL high phase right after an acknowledge. The bench provokes this by issuing repeated STARTs straight after acknowledged command bytes and by toggling the busy flag between transactions at random, so that accepted and rejected reads follow each other closely. Each outcome is judged at the pins: the ACK bit, the returned byte pair and the read address must match a model that applies the requirements to the same stimulus.

// File: rtl/i2c_rd_pkg.sv
package i2c_rd_pkg;
  localparam int BYTE_W = 8;
  localparam int REG_AW = 4;
  localparam int CNT_W  = 4;

  localparam logic [1:0] OPC_WRITE = 2'b00;
  localparam logic [1:0] OPC_READ  = 2'b11;

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_MACK} eng_st_t;
  typedef enum logic [1:0] {PH_CTRL, PH_CMD, PH_WDATA} rx_ph_t;

  typedef struct packed {
    logic   accept;
    logic   to_tx;
    logic   load_ptr;
    rx_ph_t next_ph;
  } verdict_t;
endpackage

// File: rtl/i2c_rd_cond.sv
module i2c_rd_cond #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_d;
  logic              sda_d;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_pipe[g] <= 1'b1;
          sda_pipe[g] <= 1'b1;
        end else begin
          scl_pipe[g] <= scl_i;
          sda_pipe[g] <= sda_i;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_pipe[g] <= 1'b1;
          sda_pipe[g] <= 1'b1;
        end else begin
          scl_pipe[g] <= scl_pipe[g-1];
          sda_pipe[g] <= sda_pipe[g-1];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_pipe[LAST];
      sda_d <= sda_pipe[LAST];
    end
  end

  assign scl_s     = scl_pipe[LAST];
  assign sda_s     = sda_pipe[LAST];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_rd_decode.sv
module i2c_rd_decode
  import i2c_rd_pkg::*;
#(
  parameter logic [5:0]        DEV_HI   = 6'b010111,
  parameter logic [REG_AW-1:0] NV_FIRST = 4'd2
) (
  input  rx_ph_t              ph,
  input  logic [BYTE_W-1:0]   rx_byte,
  input  logic                addr_strap,
  input  logic                nv_busy,
  input  logic [REG_AW-1:0]   ptr,
  output verdict_t            verdict
);
  logic [REG_AW-1:0] cmd_addr;
  logic [1:0]        cmd_op;
  logic              nv_block_ptr;
  logic              nv_block_cmd;

  assign cmd_addr     = rx_byte[7:4];
  assign cmd_op       = rx_byte[3:2];
  assign nv_block_ptr = nv_busy && (ptr >= NV_FIRST);
  assign nv_block_cmd = nv_busy && (cmd_addr >= NV_FIRST);

  always_comb begin
    verdict         = '0;
    verdict.next_ph = PH_WDATA;
    case (ph)
      PH_CTRL: begin
        if (rx_byte[7:1] == {DEV_HI, addr_strap}) begin
          if (!rx_byte[0]) begin
            verdict.accept  = 1'b1;
            verdict.next_ph = PH_CMD;
          end else if (!nv_block_ptr) begin
            verdict.accept = 1'b1;
            verdict.to_tx  = 1'b1;
          end
        end
      end
      PH_CMD: begin
        if (cmd_op == OPC_WRITE || (cmd_op == OPC_READ && !nv_block_cmd)) begin
          verdict.accept   = 1'b1;
          verdict.load_ptr = 1'b1;
        end
      end
      default: verdict.accept = 1'b1;
    endcase
  end
endmodule

// File: rtl/i2c_rd_engine.sv
module i2c_rd_engine
  import i2c_rd_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  verdict_t          verdict,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic              sda_oe,
  output rx_ph_t            ph,
  output logic [BYTE_W-1:0] rx_byte,
  output logic [REG_AW-1:0] ptr
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  eng_st_t           st;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] txsh;
  logic [DATA_W-1:0] word;
  logic              second;
  logic              to_tx_q;
  logic              m_ack;

  function automatic logic [BYTE_W-1:0] hi_of(input logic [DATA_W-1:0] w);
    return BYTE_W'(w >> BYTE_W);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      ph      <= PH_CTRL;
      cnt     <= '0;
      rx_byte <= '0;
      txsh    <= '0;
      word    <= '0;
      second  <= 1'b0;
      to_tx_q <= 1'b0;
      m_ack   <= 1'b0;
      sda_oe  <= 1'b0;
      ptr     <= '0;
    end else if (start_det) begin
      st     <= S_RX;
      ph     <= PH_CTRL;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      st     <= S_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (st)
        S_RX: begin
          if (scl_rise) begin
            rx_byte <= {rx_byte[BYTE_W-2:0], sda_s};
            cnt     <= cnt + 1'b1;
          end else if (scl_fall && cnt == FULL) begin
            if (verdict.accept) begin
              sda_oe  <= 1'b1;
              st      <= S_ACK;
              ph      <= verdict.next_ph;
              to_tx_q <= verdict.to_tx;
              if (verdict.load_ptr) ptr <= rx_byte[7:4];
            end else begin
              st <= S_IDLE;
            end
          end
        end
        S_ACK: begin
          if (scl_fall) begin
            cnt <= '0;
            if (to_tx_q) begin
              word   <= rf_rdata;
              txsh   <= hi_of(rf_rdata);
              sda_oe <= ~hi_of(rf_rdata)[BYTE_W-1];
              second <= 1'b0;
              st     <= S_TX;
            end else begin
              sda_oe <= 1'b0;
              st     <= S_RX;
            end
          end
        end
        S_TX: begin
          if (scl_rise) begin
            cnt <= cnt + 1'b1;
          end else if (scl_fall) begin
            if (cnt == FULL) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              st     <= S_MACK;
            end else begin
              sda_oe <= ~txsh[BYTE_W-2];
              txsh   <= txsh << 1;
            end
          end
        end
        S_MACK: begin
          if (scl_rise) begin
            m_ack <= ~sda_s;
          end else if (scl_fall) begin
            if (m_ack) begin
              st  <= S_TX;
              cnt <= '0;
              if (!second) begin
                txsh   <= word[BYTE_W-1:0];
                sda_oe <= ~word[BYTE_W-1];
                second <= 1'b1;
              end else begin
                word   <= rf_rdata;
                txsh   <= hi_of(rf_rdata);
                sda_oe <= ~hi_of(rf_rdata)[BYTE_W-1];
                second <= 1'b0;
              end
            end else begin
              st <= S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R11: the data line drive only moves during the SCL low phase
  p_oe_scl_low_r11: assert property (@(posedge clk) disable iff (rst)
    (sda_oe != $past(sda_oe)) |-> !scl_s);

  // R4, R9: while ignoring the bus the target never pulls SDA
  p_idle_released_r4: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE) |-> !sda_oe);

  // R3: the pointer moves only after a command byte was judged
  p_ptr_on_cmd_r3: assert property (@(posedge clk) disable iff (rst)
    (ptr != $past(ptr)) |-> ($past(st) == S_RX && $past(ph) == PH_CMD));

  // R2: throughout the acknowledge slot the line is held low
  p_ack_drive_r2: assert property (@(posedge clk) disable iff (rst)
    (st == S_ACK) |-> sda_oe);
endmodule

// File: rtl/i2c_rd_target.sv
module i2c_rd_target
  import i2c_rd_pkg::*;
#(
  parameter logic [5:0]        DEV_HI      = 6'b010111,
  parameter logic [REG_AW-1:0] NV_FIRST    = 4'd2,
  parameter int                DATA_W      = 9,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              addr_strap,
  input  logic              nv_busy,
  output logic [REG_AW-1:0] rf_raddr,
  input  logic [DATA_W-1:0] rf_rdata
);
  logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  rx_ph_t            ph;
  logic [BYTE_W-1:0] rx_byte;
  logic [REG_AW-1:0] ptr;
  verdict_t          verdict;

  i2c_rd_cond #(.STAGES(SYNC_STAGES)) u_cond (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_rd_decode #(.DEV_HI(DEV_HI), .NV_FIRST(NV_FIRST)) u_dec (
    .ph         (ph),
    .rx_byte    (rx_byte),
    .addr_strap (addr_strap),
    .nv_busy    (nv_busy),
    .ptr        (ptr),
    .verdict    (verdict)
  );

  i2c_rd_engine #(.DATA_W(DATA_W)) u_eng (
    .clk       (clk),
    .rst       (rst),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .verdict   (verdict),
    .rf_rdata  (rf_rdata),
    .sda_oe    (sda_oe),
    .ph        (ph),
    .rx_byte   (rx_byte),
    .ptr       (ptr)
  );

  assign rf_raddr = ptr;
endmodule

// File: tb/sim_i2c_rd_target.sv
`timescale 1ns/1ps
module sim_i2c_rd_target;
  localparam logic [5:0] DEV_HI = 6'b010111;
  localparam int         NVF    = 2;
  localparam int         Q      = 5;

  logic       clk = 1'b0, rst = 1'b1;
  logic       scl_m = 1'b1, sda_m = 1'b1, nv_busy = 1'b0;
  logic       sda_oe;
  logic [3:0] rf_raddr;
  logic [8:0] rf_rdata;
  logic [8:0] mem [16];
  wire        sda_line = sda_m & ~sda_oe;

  int checks = 0, errors = 0, oe_viol = 0;
  logic [3:0] ptr_exp = 4'd0;
  logic prev_oe = 1'b0;

  always #2.5 clk = ~clk;

  i2c_rd_target u0 (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_strap(1'b1), .nv_busy(nv_busy), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata)
  );

  always @(posedge clk) rf_rdata <= mem[rf_raddr];

  always @(negedge clk) begin
    if (!rst && sda_oe != prev_oe && scl_m) oe_viol++;
    prev_oe = sda_oe;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [7:0] ctrl(input bit rw);
    return {DEV_HI, 1'b1, rw};
  endfunction

  task automatic bus_start();
    sda_m = 1'b1; wclk(Q); scl_m = 1'b1; wclk(Q);
    sda_m = 1'b0; wclk(Q); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wclk(Q); scl_m = 1'b1; wclk(Q); sda_m = 1'b1; wclk(Q);
  endtask

  task automatic bit_write(input bit b);
    wclk(Q); sda_m = b; wclk(Q); scl_m = 1'b1; wclk(2*Q); scl_m = 1'b0;
  endtask

  task automatic bit_read(output bit b);
    sda_m = 1'b1; wclk(2*Q); scl_m = 1'b1; wclk(Q); b = sda_line; wclk(Q); scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v, output bit acked);
    bit x;
    for (int i = 7; i >= 0; i--) bit_write(v[i]);
    bit_read(x);
    acked = !x;
  endtask

  task automatic recv_byte(output logic [7:0] v, input bit mack);
    bit x;
    for (int i = 7; i >= 0; i--) begin
      bit_read(x);
      v[i] = x;
    end
    bit_write(!mack);
  endtask

  function automatic bit cmd_ok(input logic [3:0] a, input logic [1:0] op, input bit busy);
    return (op == 2'b00) || (op == 2'b11 && !(busy && a >= NVF));
  endfunction

  // command write transaction, possibly with an undefined opcode
  task automatic t_cmd(input logic [3:0] a, input logic [1:0] op, input int ndata, input bit busy);
    bit ack, e;
    nv_busy = busy;
    bus_start();
    send_byte(ctrl(1'b0), ack);
    chk(ack == 1'b1, "R2 control write ack", ack, 1);
    e = cmd_ok(a, op, busy);
    send_byte({a, op, 2'b01}, ack);
    chk(ack == e, e ? "R3 command ack" : "R4 undefined command nack", ack, e);
    if (e) ptr_exp = a;
    for (int k = 0; k < ndata; k++) begin
      send_byte(e ? 8'($urandom) : ctrl(1'b1), ack);
      chk(ack == e, e ? "R3 data byte ack" : "R4 ignored after bad command", ack, e);
    end
    bus_stop();
    chk(rf_raddr == ptr_exp, "R3 pointer on read port", rf_raddr, ptr_exp);
  endtask

  // read transaction: optional random-read prefix, npairs byte pairs
  task automatic t_read(input bit rnd, input logic [3:0] a, input int npairs,
                        input bit nack_hi, input bit busy);
    bit ack, e;
    logic [8:0] d;
    logic [7:0] hb, lb;
    nv_busy = busy;
    bus_start();
    if (rnd) begin
      send_byte(ctrl(1'b0), ack);
      chk(ack == 1'b1, "R7 control write ack", ack, 1);
      e = cmd_ok(a, 2'b11, busy);
      send_byte({a, 2'b11, 2'b00}, ack);
      chk(ack == e, "R10 read command verdict", ack, e);
      if (!e) begin bus_stop(); return; end
      ptr_exp = a;
      bus_start();
    end
    e = !(busy && ptr_exp >= NVF);
    send_byte(ctrl(1'b1), ack);
    chk(ack == e, "R10 read control verdict", ack, e);
    if (!e) begin bus_stop(); return; end
    for (int p = 0; p < npairs; p++) begin
      d = mem[ptr_exp];
      recv_byte(hb, !nack_hi);
      chk(hb == {7'b0, d[8]}, "R5 high byte", hb, {7'b0, d[8]});
      if (nack_hi) begin
        recv_byte(lb, 1'b0);
        chk(lb == 8'hFF, "R9 released after nack", lb, 8'hFF);
        break;
      end
      if (npairs > 1) mem[ptr_exp] = 9'($urandom);
      recv_byte(lb, p < npairs - 1);
      chk(lb == d[7:0], npairs > 1 ? "R8 continuous low byte" : "R5 low byte", lb, d[7:0]);
    end
    bus_stop();
    chk(rf_raddr == ptr_exp, "R9 pointer kept after read", rf_raddr, ptr_exp);
  endtask

  task automatic t_badaddr();
    bit ack;
    bus_start();
    send_byte({DEV_HI, 1'b0, 1'b1}, ack);
    chk(ack == 1'b0, "R2 wrong address nack", ack, 0);
    send_byte(ctrl(1'b1), ack);
    chk(ack == 1'b0, "R2 silent until START", ack, 0);
    bus_stop();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 180000, 0);
    finish_run();
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h1C2D3);
    for (int i = 0; i < 16; i++) mem[i] = 9'($urandom);
    mem[0] = 9'h1A5;
    wclk(10);
    rst = 1'b0;
    wclk(5);
    chk(sda_oe == 1'b0, "R1 reset sda_oe", sda_oe, 0);
    chk(rf_raddr == 4'd0, "R1 reset read address", rf_raddr, 0);

    t_read(1'b0, 4'd0, 1, 1'b0, 1'b0);          // R6 read of register 0
    t_cmd(4'd5, 2'b00, 1, 1'b0);                // R3 write command
    t_read(1'b0, 4'd0, 3, 1'b0, 1'b0);          // R8 continuous
    t_cmd(4'd3, 2'b01, 1, 1'b0);                // R4
    t_cmd(4'd4, 2'b10, 2, 1'b0);                // R4
    t_read(1'b1, 4'd7, 1, 1'b0, 1'b1);          // R10 rejected
    t_read(1'b1, 4'd1, 1, 1'b0, 1'b1);          // R7 volatile under busy
    t_cmd(4'd9, 2'b00, 0, 1'b1);                // R10 write still accepted
    t_read(1'b0, 4'd0, 1, 1'b0, 1'b1);          // R10 control nack
    t_read(1'b1, 4'd12, 2, 1'b0, 1'b0);         // R7 random read
    t_read(1'b0, 4'd0, 1, 1'b1, 1'b0);          // R9 nack after high
    t_read(1'b0, 4'd0, 1, 1'b0, 1'b0);          // R9 pointer reused
    t_badaddr();                                // R2

    for (int it = 0; it < 50; it++) begin
      case ($urandom % 5)
        0: t_cmd(4'($urandom), 2'($urandom), $urandom % 3, 1'($urandom));
        1: t_read(1'b1, 4'($urandom), 1 + $urandom % 3, 1'b0, 1'($urandom));
        2: t_read(1'b0, 4'd0, 1 + $urandom % 2, ($urandom % 4) == 0, 1'($urandom));
        3: t_badaddr();
        default: t_cmd(4'($urandom), 2'b00, 0, 1'b0);
      endcase
    end

    chk(oe_viol == 0, "R11 sda_oe moved while SCL high", oe_viol, 0);
    finish_run();
  end
endmodule